// File: doc/BRIEF.md
# Package Low-Power State Controller

This block sequences a two-core package through its deepest idle states. It watches four active-low sideband lines from the chipset: stop-clock, sleep, deep-sleep and deeper-stop. They step the package from the active level through Stop-Grant, Sleep and Deep Sleep. From Deep Sleep the controller picks one of three deeper targets. Plain Deeper Sleep is the default. The enhanced Deeper Sleep sub-state is chosen once the shared cache is empty and every core asks for C4. Full power-down is chosen once the cache is empty and every core reports CC6.

Each target drives its own voltage-ID code. The enhanced sub-state first completes a notify handshake with the chipset. Power-down first saves both cores' state to an on-die SRAM through a handshake. Leaving power-down is staged by the order in which the lines are released. Releasing deep-sleep restarts the PLL and selects the low-frequency voltage code. Releasing sleep pulses core reset and restores both cores, whichever core the wake event was aimed at. Both cores then report CC0.

The block also raises a sticky protocol-error flag when a sideband line moves while a handshake is open. A sticky timeout flag is raised when an acknowledge does not arrive in time. The voltage regulator, PLL, SRAM and cache-shrink logic are outside the block and are reached only through these handshakes.

Top module: `pkg_lowpwr_ctrl`

## Requirements
- R1: After reset, vid_o equals VID_ACTIVE (default 7'h20), pll_en_o is 1, and all request, reset, CC0, wake and error outputs are 0.
- R2: Asserting deeper_stop_ni (driving it 0) has an effect only in Deep Sleep, that is with stop_clk_ni, sleep_ni and deep_sleep_ni all at 0. At any shallower level, vid_o stays unchanged.
- R3: In Deep Sleep, asserting deeper-stop without the enhanced or power-down conditions sets vid_o to VID_DEEPER (7'h30) one cycle later. Releasing deeper-stop restores VID_ACTIVE one cycle later.
- R4: In Deep Sleep, with cache_zero_i at 1 and every core's 3-bit C-state code at 4 (C4), asserting deeper-stop raises notify_req_o and leaves vid_o unchanged. The cycle after notify_ack_i is sampled high, notify_req_o drops and vid_o becomes VID_ENH (7'h38).
- R5: In Deep Sleep, with cache_zero_i at 1 and every core's C-state code at 6 (CC6), asserting deeper-stop raises save_req_o and leaves vid_o unchanged. This takes priority over R4. The cycle after save_ack_i, vid_o becomes VID_PD (7'h3C) and pll_en_o drops to 0.
- R6: In power-down, releasing deeper-stop alone keeps vid_o at VID_PD. Releasing deep-sleep afterwards sets vid_o to VID_LFM (7'h28) and pll_en_o to 1.
- R7: After that, releasing sleep raises core_rst_o for exactly one cycle. restore_req_o rises in the same cycle and stays high until restore_ack_i.
- R8: The cycle after restore_ack_i, every bit of core_cc0_o is 1 for exactly one cycle and the package is back at Stop-Grant. Releasing stop-clock then sets vid_o to VID_ACTIVE.
- R9: In Deeper Sleep or its enhanced sub-state, deeper_wake_o is 1 when any core's C-state code differs from 4 or any core_plow_i bit is 0. Otherwise it is 0.
- R10: While a notify, save or restore request is open, any change of the four sideband lines sets proto_err_o. The flag stays set until reset, and the open handshake still completes on its acknowledge.
- R11: If a request stays open without its acknowledge for TIMEOUT cycles, ack_timeout_o is set and stays set. The sequence still advances when the acknowledge finally arrives.
- R12: vid_o changes only in cycles where the controller's state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_clk_ni | input | 1 | Stop-clock sideband, active low |
| sleep_ni | input | 1 | Sleep sideband, active low |
| deep_sleep_ni | input | 1 | Deep-sleep sideband, active low |
| deeper_stop_ni | input | 1 | Deeper-stop sideband, active low |
| core_cst_i | input | NCORES*3 | Per-core C-state code (0 CC0, 4 C4, 6 CC6) |
| core_plow_i | input | NCORES | Per-core request for the lowest performance state |
| cache_zero_i | input | 1 | Shared cache shrunk to zero ways |
| notify_ack_i | input | 1 | Chipset notify acknowledge |
| save_ack_i | input | 1 | SRAM save done |
| restore_ack_i | input | 1 | SRAM restore done |
| vid_o | output | VID_W | Voltage-ID code |
| deeper_wake_o | output | 1 | Cores want to leave Deeper Sleep |
| notify_req_o | output | 1 | Chipset notify request |
| pll_en_o | output | 1 | PLL enable |
| save_req_o | output | 1 | SRAM save request |
| restore_req_o | output | 1 | SRAM restore request |
| core_rst_o | output | 1 | Core reset pulse |
| core_cc0_o | output | NCORES | Per-core CC0 report pulse |
| proto_err_o | output | 1 | Sticky sideband protocol error |
| ack_timeout_o | output | 1 | Sticky acknowledge timeout |

## Verification
The same edge can complete a handshake and flag a protocol error. This happens when the chipset notify acknowledge arrives in the same cycle that a sideband line moves. The bench provokes it by raising notify_ack_i and releasing sleep_ni at the same negative edge while the notify request is open. It then requires two results one cycle later: vid_o has moved to the enhanced code, showing the acknowledge was honoured, and proto_err_o is set, showing the line change was not lost.

// File: rtl/pkg_lowpwr_pkg.sv
package pkg_lowpwr_pkg;
  localparam int CST_W = 3;
  localparam logic [CST_W-1:0] CST_CC0 = 3'd0;
  localparam logic [CST_W-1:0] CST_C4  = 3'd4;
  localparam logic [CST_W-1:0] CST_CC6 = 3'd6;
  localparam int SIDE_W = 4;

  typedef enum logic [3:0] {
    ST_ACTIVE, ST_STOPGNT, ST_SLEEP, ST_DEEP,
    ST_DEEPER, ST_ENH_NTF, ST_ENH,
    ST_PD_SAVE, ST_PD, ST_PD_W1, ST_PD_W2, ST_PD_RST
  } lp_state_e;
endpackage

// File: rtl/lp_core_eval.sv
module lp_core_eval
  import pkg_lowpwr_pkg::*;
#(
  parameter int NCORES = 2
) (
  input  logic [NCORES*CST_W-1:0] core_cst_i,
  input  logic [NCORES-1:0]       core_plow_i,
  output logic                    all_c4_o,
  output logic                    all_cc6_o,
  output logic                    wake_any_o
);
  logic [NCORES-1:0] is_c4, is_cc6;

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    assign is_c4[g]  = core_cst_i[g*CST_W +: CST_W] == CST_C4;
    assign is_cc6[g] = core_cst_i[g*CST_W +: CST_W] == CST_CC6;
  end

  assign all_c4_o   = &is_c4;
  assign all_cc6_o  = &is_cc6;
  assign wake_any_o = |(~is_c4 | ~core_plow_i);
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import pkg_lowpwr_pkg::*;
#(
  parameter int               VID_W      = 7,
  parameter logic [VID_W-1:0] VID_ACTIVE = 7'h20,
  parameter logic [VID_W-1:0] VID_DEEPER = 7'h30,
  parameter logic [VID_W-1:0] VID_ENH    = 7'h38,
  parameter logic [VID_W-1:0] VID_PD     = 7'h3C,
  parameter logic [VID_W-1:0] VID_LFM    = 7'h28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_a_i,
  input  logic             sleep_a_i,
  input  logic             deep_a_i,
  input  logic             deeper_a_i,
  input  logic             all_c4_i,
  input  logic             all_cc6_i,
  input  logic             cache_zero_i,
  input  logic             notify_ack_i,
  input  logic             save_ack_i,
  input  logic             restore_ack_i,
  output lp_state_e        state_o,
  output logic [VID_W-1:0] vid_o,
  output logic             pll_en_o,
  output logic             core_rst_o,
  output logic             cc0_pulse_o
);
  lp_state_e        state_q, state_d;
  logic [VID_W-1:0] vid_q, vid_d;
  logic             pll_q, pll_d, rst_d, cc0_d;

  always_comb begin
    state_d = state_q;
    vid_d   = vid_q;
    pll_d   = pll_q;
    rst_d   = 1'b0;
    cc0_d   = 1'b0;
    unique case (state_q)
      ST_ACTIVE:  if (stop_a_i) state_d = ST_STOPGNT;
      ST_STOPGNT: begin
        if (!stop_a_i) begin
          state_d = ST_ACTIVE;
          vid_d   = VID_ACTIVE;
        end else if (sleep_a_i) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!sleep_a_i)    state_d = ST_STOPGNT;
        else if (deep_a_i) state_d = ST_DEEP;
      end
      ST_DEEP: begin
        if (!deep_a_i) state_d = ST_SLEEP;
        else if (deeper_a_i) begin
          // power-down outranks the enhanced sub-state
          if (cache_zero_i && all_cc6_i)     state_d = ST_PD_SAVE;
          else if (cache_zero_i && all_c4_i) state_d = ST_ENH_NTF;
          else begin
            state_d = ST_DEEPER;
            vid_d   = VID_DEEPER;
          end
        end
      end
      ST_DEEPER, ST_ENH: begin
        if (!deeper_a_i) begin
          state_d = ST_DEEP;
          vid_d   = VID_ACTIVE;
        end
      end
      ST_ENH_NTF: begin
        if (notify_ack_i) begin
          state_d = ST_ENH;
          vid_d   = VID_ENH;
        end
      end
      ST_PD_SAVE: begin
        if (save_ack_i) begin
          state_d = ST_PD;
          vid_d   = VID_PD;
          pll_d   = 1'b0;
        end
      end
      ST_PD:    if (!deeper_a_i) state_d = ST_PD_W1;
      ST_PD_W1: begin
        if (!deep_a_i) begin
          state_d = ST_PD_W2;
          vid_d   = VID_LFM;
          pll_d   = 1'b1;
        end
      end
      ST_PD_W2: begin
        if (!sleep_a_i) begin
          state_d = ST_PD_RST;
          rst_d   = 1'b1;
        end
      end
      ST_PD_RST: begin
        if (restore_ack_i) begin
          state_d = ST_STOPGNT;
          cc0_d   = 1'b1;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACTIVE;
      vid_q       <= VID_ACTIVE;
      pll_q       <= 1'b1;
      core_rst_o  <= 1'b0;
      cc0_pulse_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      vid_q       <= vid_d;
      pll_q       <= pll_d;
      core_rst_o  <= rst_d;
      cc0_pulse_o <= cc0_d;
    end
  end

  assign state_o  = state_q;
  assign vid_o    = vid_q;
  assign pll_en_o = pll_q;
endmodule

// File: rtl/lp_hs_timer.sv
module lp_hs_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic ack_i,
  output logic timeout_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (!busy_i || ack_i) begin
      cnt_q <= '0;
    end else begin
      if (cnt_q == LIMIT) timeout_o <= 1'b1;
      else                cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lp_side_watch.sv
module lp_side_watch
  import pkg_lowpwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIDE_W-1:0] side_i,
  input  logic              busy_i,
  output logic              err_o
);
  logic [SIDE_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      err_o  <= 1'b0;
    end else begin
      prev_q <= side_i;
      if (busy_i && (side_i != prev_q)) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pkg_lowpwr_ctrl.sv
module pkg_lowpwr_ctrl
  import pkg_lowpwr_pkg::*;
#(
  parameter int               NCORES     = 2,
  parameter int               VID_W      = 7,
  parameter int               TIMEOUT    = 1024,
  parameter logic [VID_W-1:0] VID_ACTIVE = 7'h20,
  parameter logic [VID_W-1:0] VID_DEEPER = 7'h30,
  parameter logic [VID_W-1:0] VID_ENH    = 7'h38,
  parameter logic [VID_W-1:0] VID_PD     = 7'h3C,
  parameter logic [VID_W-1:0] VID_LFM    = 7'h28
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stop_clk_ni,
  input  logic                    sleep_ni,
  input  logic                    deep_sleep_ni,
  input  logic                    deeper_stop_ni,
  input  logic [NCORES*CST_W-1:0] core_cst_i,
  input  logic [NCORES-1:0]       core_plow_i,
  input  logic                    cache_zero_i,
  input  logic                    notify_ack_i,
  input  logic                    save_ack_i,
  input  logic                    restore_ack_i,
  output logic [VID_W-1:0]        vid_o,
  output logic                    deeper_wake_o,
  output logic                    notify_req_o,
  output logic                    pll_en_o,
  output logic                    save_req_o,
  output logic                    restore_req_o,
  output logic                    core_rst_o,
  output logic [NCORES-1:0]       core_cc0_o,
  output logic                    proto_err_o,
  output logic                    ack_timeout_o
);
  lp_state_e state;
  logic all_c4, all_cc6, wake_any, cc0_pulse, busy, ack_sel;

  lp_core_eval #(.NCORES(NCORES)) u_eval (
    .core_cst_i (core_cst_i),
    .core_plow_i(core_plow_i),
    .all_c4_o   (all_c4),
    .all_cc6_o  (all_cc6),
    .wake_any_o (wake_any)
  );

  lp_seq_fsm #(
    .VID_W(VID_W), .VID_ACTIVE(VID_ACTIVE), .VID_DEEPER(VID_DEEPER),
    .VID_ENH(VID_ENH), .VID_PD(VID_PD), .VID_LFM(VID_LFM)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_a_i     (!stop_clk_ni),
    .sleep_a_i    (!sleep_ni),
    .deep_a_i     (!deep_sleep_ni),
    .deeper_a_i   (!deeper_stop_ni),
    .all_c4_i     (all_c4),
    .all_cc6_i    (all_cc6),
    .cache_zero_i (cache_zero_i),
    .notify_ack_i (notify_ack_i),
    .save_ack_i   (save_ack_i),
    .restore_ack_i(restore_ack_i),
    .state_o      (state),
    .vid_o        (vid_o),
    .pll_en_o     (pll_en_o),
    .core_rst_o   (core_rst_o),
    .cc0_pulse_o  (cc0_pulse)
  );

  assign notify_req_o  = state == ST_ENH_NTF;
  assign save_req_o    = state == ST_PD_SAVE;
  assign restore_req_o = state == ST_PD_RST;
  assign busy          = notify_req_o | save_req_o | restore_req_o;
  assign ack_sel       = (notify_req_o & notify_ack_i) | (save_req_o & save_ack_i)
                       | (restore_req_o & restore_ack_i);
  assign deeper_wake_o = ((state == ST_DEEPER) || (state == ST_ENH)) && wake_any;
  assign core_cc0_o    = {NCORES{cc0_pulse}};

  lp_hs_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .ack_i    (ack_sel),
    .timeout_o(ack_timeout_o)
  );

  lp_side_watch u_watch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .side_i({stop_clk_ni, sleep_ni, deep_sleep_ni, deeper_stop_ni}),
    .busy_i(busy),
    .err_o (proto_err_o)
  );
endmodule

// File: rtl/pkg_lowpwr_ctrl_chk.sv
module pkg_lowpwr_ctrl_chk
  import pkg_lowpwr_pkg::*;
#(
  parameter int               NCORES  = 2,
  parameter int               VID_W   = 7,
  parameter logic [VID_W-1:0] VID_ENH = 7'h38,
  parameter logic [VID_W-1:0] VID_PD  = 7'h3C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input lp_state_e         state,
  input logic [VID_W-1:0]  vid_o,
  input logic              notify_req_o,
  input logic              save_req_o,
  input logic              restore_req_o,
  input logic              core_rst_o,
  input logic [NCORES-1:0] core_cc0_o,
  input logic              proto_err_o,
  input logic              ack_timeout_o,
  input logic              pll_en_o
);
  p_one_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({notify_req_o, save_req_o, restore_req_o}));

  p_enh_after_notify_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_o == VID_ENH) |-> $past(notify_req_o));

  p_pd_after_save_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_o == VID_PD) |-> ($past(save_req_o) && !pll_en_o));

  p_rst_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !core_rst_o);

  p_rst_with_restore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> restore_req_o);

  p_cc0_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|core_cc0_o) |-> ((&core_cc0_o) && $past(restore_req_o)));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  p_to_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_timeout_o |=> ack_timeout_o);

  p_vid_on_edge_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vid_o) |-> !$stable(state));
endmodule

bind pkg_lowpwr_ctrl pkg_lowpwr_ctrl_chk #(
  .NCORES(NCORES), .VID_W(VID_W), .VID_ENH(VID_ENH), .VID_PD(VID_PD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state(state), .vid_o(vid_o),
  .notify_req_o(notify_req_o), .save_req_o(save_req_o),
  .restore_req_o(restore_req_o), .core_rst_o(core_rst_o),
  .core_cc0_o(core_cc0_o), .proto_err_o(proto_err_o),
  .ack_timeout_o(ack_timeout_o), .pll_en_o(pll_en_o)
);

// File: tb/pkg_lowpwr_ctrl_tb_top.sv
module pkg_lowpwr_ctrl_tb_top;
  localparam int TO = 20;
  localparam logic [6:0] V_ACT = 7'h20, V_DPR = 7'h30, V_ENH = 7'h38,
                         V_PD = 7'h3C, V_LFM = 7'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1, deeper_n = 1'b1;
  logic [5:0] cst = 6'h0;
  logic [1:0] plow = 2'b11;
  logic cz = 1'b0, n_ack = 1'b0, s_ack = 1'b0, r_ack = 1'b0;
  logic [6:0] vid;
  logic wake, n_req, pll, s_req, r_req, crst, perr, tout;
  logic [1:0] cc0;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pkg_lowpwr_ctrl #(.TIMEOUT(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stop_clk_ni(stop_n), .sleep_ni(sleep_n),
    .deep_sleep_ni(deep_n), .deeper_stop_ni(deeper_n), .core_cst_i(cst),
    .core_plow_i(plow), .cache_zero_i(cz), .notify_ack_i(n_ack),
    .save_ack_i(s_ack), .restore_ack_i(r_ack), .vid_o(vid),
    .deeper_wake_o(wake), .notify_req_o(n_req), .pll_en_o(pll),
    .save_req_o(s_req), .restore_req_o(r_req), .core_rst_o(crst),
    .core_cc0_o(cc0), .proto_err_o(perr), .ack_timeout_o(tout)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    stop_n = 1; sleep_n = 1; deep_n = 1; deeper_n = 1;
    cz = 0; n_ack = 0; s_ack = 0; r_ack = 0; cst = 6'h0; plow = 2'b11;
    rst_n = 0; step(2); rst_n = 1; step(1);
  endtask

  task automatic go_deep();
    stop_n = 0; step(1); sleep_n = 0; step(1); deep_n = 0; step(1);
  endtask

  task automatic go_active();
    deep_n = 1; step(1); sleep_n = 1; step(1); stop_n = 1; step(1);
  endtask

  task automatic t_reset();
    chk("R1 vid", vid, V_ACT);
    chk("R1 pll", pll, 1);
    chk("R1 outs", {n_req, s_req, r_req, crst, cc0, wake, perr, tout}, 0);
  endtask

  task automatic t_gate();
    stop_n = 0; step(1); sleep_n = 0; step(1);
    deeper_n = 0; step(2);
    chk("R2 vid in sleep", vid, V_ACT);
    deeper_n = 1; step(1);
    deep_n = 0; step(2);
    chk("R2 vid in deep", vid, V_ACT);
    go_active();
  endtask

  task automatic t_deeper();
    cst = {3'd4, 3'd4}; cz = 0;
    go_deep();
    deeper_n = 0; step(1);
    chk("R3 vid deeper", vid, V_DPR);
    chk("R9 wake idle", wake, 0);
    cst = {3'd4, 3'd0}; step(1);
    chk("R9 wake on cstate", wake, 1);
    cst = {3'd4, 3'd4}; plow = 2'b01; step(1);
    chk("R9 wake on pstate", wake, 1);
    plow = 2'b11;
    deeper_n = 1; step(1);
    chk("R3 vid exit", vid, V_ACT);
    go_active();
  endtask

  task automatic t_enh();
    cst = {3'd4, 3'd4}; cz = 1;
    go_deep();
    deeper_n = 0; step(1);
    chk("R4 notify req", n_req, 1);
    chk("R4 vid held", vid, V_ACT);
    step(3);
    chk("R4 vid held wait", vid, V_ACT);
    n_ack = 1; step(1); n_ack = 0;
    chk("R4 vid enh", vid, V_ENH);
    chk("R4 notify drop", n_req, 0);
    deeper_n = 1; step(1);
    chk("R3 enh exit", vid, V_ACT);
    go_active();
  endtask

  task automatic t_pd();
    cst = {3'd6, 3'd6}; cz = 1;
    go_deep();
    deeper_n = 0; step(1);
    chk("R5 save req", s_req, 1);
    chk("R5 no notify", n_req, 0);
    chk("R5 vid held", vid, V_ACT);
    s_ack = 1; step(1); s_ack = 0;
    chk("R5 vid pd", vid, V_PD);
    chk("R5 pll off", pll, 0);
    deeper_n = 1; step(2);
    chk("R6 vid stays", vid, V_PD);
    chk("R6 pll stays off", pll, 0);
    deep_n = 1; step(1);
    chk("R6 vid lfm", vid, V_LFM);
    chk("R6 pll on", pll, 1);
    cst = {3'd0, 3'd6};
    sleep_n = 1; step(1);
    chk("R7 rst", crst, 1);
    chk("R7 restore req", r_req, 1);
    step(1);
    chk("R7 rst one cycle", crst, 0);
    chk("R7 restore held", r_req, 1);
    r_ack = 1; step(1); r_ack = 0;
    chk("R8 cc0 both", cc0, 2'b11);
    chk("R8 restore drop", r_req, 0);
    step(1);
    chk("R8 cc0 pulse", cc0, 0);
    stop_n = 1; step(1);
    chk("R8 vid active", vid, V_ACT);
  endtask

  task automatic t_proto();
    cst = {3'd4, 3'd4}; cz = 1;
    go_deep();
    deeper_n = 0; step(1);
    chk("R10 no err yet", perr, 0);
    sleep_n = 1; n_ack = 1; step(1); n_ack = 0;
    chk("R10 err set", perr, 1);
    chk("R4 ack same cycle", vid, V_ENH);
    step(2);
    chk("R10 err sticky", perr, 1);
    do_reset();
  endtask

  task automatic t_timeout();
    cst = {3'd6, 3'd6}; cz = 1;
    go_deep();
    deeper_n = 0; step(5);
    chk("R11 no timeout early", tout, 0);
    step(TO);
    chk("R11 timeout", tout, 1);
    s_ack = 1; step(1); s_ack = 0;
    chk("R11 advances", vid, V_PD);
    chk("R11 sticky", tout, 1);
    do_reset();
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset();
        t_gate();
        t_deeper();
        t_enh();
        t_pd();
        t_proto();
        t_timeout();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule